// File: doc/BRIEF.md
# Dual-Channel Tamper Detector

This block watches two tamper inputs and reports any intrusion attempt. Channel 0 reads one of two input pins, chosen by a configuration bit. Channel 1 always reads the second pin. Both channels share one filter-mode field. A zero mode makes each channel look for a single edge on its synchronized input. A nonzero mode makes each channel sample its input on a slow tick and wait until a run of consecutive active samples reaches the length the mode asks for.

Each channel has its own enable, its own polarity bit and its own sticky flag. A detection always sends a one-cycle pulse that wipes the battery-backed registers. When enabled, it also sends a one-cycle pulse to the time-stamp unit. The interrupt output is the OR of the two flags, gated by an interrupt enable. Software clears a flag by pulsing that channel's clear strobe.

Top module: `tamper_detect`

## Requirements
- R1: Channel 0 reads `pin_a` when `ch0_pin_sel` is 0 and `pin_b` when it is 1. Channel 1 always reads `pin_b`. Activity on the pin a channel does not read leaves that channel's flag at 0.
- R2: With `filt_mode` = 0, a channel detects one edge of its input. Polarity 0 selects rising edges and polarity 1 selects falling edges. The flag is set on the third rising clock edge after the pin changes. The edge of the other direction causes no detection.
- R3: With `filt_mode` set to 1, 2 or 3, a detection needs 2, 4 or 8 consecutive samples at the active level. Polarity 0 makes high the active level and polarity 1 makes low the active level. A shorter active run gives no detection.
- R4: In level mode, a sample is taken once every 2^(`samp_rate`+1) clock cycles. For a pin held active from a given clock edge, the flag is still 0 (need-1)·P+2 edges later and is 1 by need·P+2 edges later, where P is the sample period.
- R5: A channel's flag stays at 1 until a cycle with that channel's `flag_clr` bit high, which returns it to 0 on the next edge. A detection in the same cycle wins over the clear.
- R6: `irq` is high exactly when `irq_en` is 1 and at least one flag is 1.
- R7: When `ts_on_tamper` is 1, each detection gives a one-cycle `ts_pulse` in the same cycle as the erase pulse. When `ts_on_tamper` is 0, no `ts_pulse` is produced.
- R8: Every detection on either channel gives exactly one one-cycle `erase_pulse`, in the same cycle the flag becomes visible.
- R9: A channel whose enable is 0 never sets its flag and never causes an erase or time-stamp pulse.
- R10: In level mode, after a detection, a channel does not detect again until it has taken at least one inactive sample, however long the input stays active.
- R11: After reset, the flags, `irq`, `ts_pulse` and `erase_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | First tamper pin (asynchronous) |
| pin_b | input | 1 | Second tamper pin (asynchronous) |
| ch0_pin_sel | input | 1 | Selects the pin for channel 0: 0 = pin_a, 1 = pin_b |
| ch_en | input | 2 | Per-channel enable |
| ch_pol | input | 2 | Per-channel polarity: 0 = rising/high, 1 = falling/low |
| filt_mode | input | 2 | 0 = edge mode; 1, 2, 3 = level mode needing 2, 4, 8 samples |
| samp_rate | input | 3 | Level-mode sample period exponent: period 2^(value+1) cycles |
| ts_on_tamper | input | 1 | Enables the time-stamp pulse on detection |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 2 | Per-channel flag clear strobe |
| flags | output | 2 | Sticky per-channel tamper flags |
| irq | output | 1 | Tamper interrupt |
| ts_pulse | output | 1 | One-cycle request to the time-stamp unit |
| erase_pulse | output | 1 | One-cycle erase request to the battery-backed registers |

## Verification
In edge mode the timing is fixed. The pin passes two synchronizer stages and the result is registered once, so the bench changes a pin just after a falling clock edge. It then expects the flag, erase and time-stamp outputs low after two rising edges, high after the third and the pulses gone after the fourth.

In level mode the phase of the free-running sample tick is not visible at the ports. The bench therefore checks the two limits from R4 for every filter mode and every sample rate: the flag must still be low at the earliest edge and set at the latest. A counter watching `erase_pulse` at every falling edge checks that each detection gives exactly one pulse, and that ignored activity gives none.

// File: rtl/tamp_pkg.sv
package tamp_pkg;

  localparam int FILT_W = 2;
  localparam int RATE_W = 3;
  // prescaler must cover the longest sample period 2^(2^RATE_W)
  localparam int PRE_W  = 1 << RATE_W;
  // longest run length asked for by the widest filter code
  localparam int MAX_NEED = 1 << ((1 << FILT_W) - 1);
  localparam int RUN_W  = $clog2(MAX_NEED) + 1;

  typedef enum logic [FILT_W-1:0] {
    FILT_EDGE = 2'd0,
    FILT_RUN2 = 2'd1,
    FILT_RUN4 = 2'd2,
    FILT_RUN8 = 2'd3
  } filt_e;

  // number of consecutive active samples a level-mode code requires
  function automatic logic [RUN_W-1:0] run_needed(input logic [FILT_W-1:0] code);
    logic [RUN_W-1:0] n;
    n = RUN_W'(1) << code;
    return n;
  endfunction

  // sample tick: low (rate+1) prescaler bits all ones, once per 2^(rate+1) cycles
  function automatic logic tick_hit(input logic [PRE_W-1:0] cnt,
                                    input logic [RATE_W-1:0] rate);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((33'd1 << (int'(rate) + 1)) - 33'd1);
    return (cnt & mask) == mask;
  endfunction

endpackage

// File: rtl/tamp_sync.sv
module tamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tamp_prescale.sv
module tamp_prescale
  import tamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = tick_hit(cnt, rate);
endmodule

// File: rtl/tamp_chan.sv
module tamp_chan
  import tamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin,
  input  logic              en,
  input  logic              pol,
  input  logic [FILT_W-1:0] filt,
  input  logic              tick,
  output logic              det
);
  logic             act, act_q;
  logic             edge_hit, lvl_hit, level_mode;
  logic             armed;
  logic [RUN_W-1:0] run, last_idx;

  // normalized: 1 means the pin is at its active level
  assign act        = sin ^ pol;
  assign level_mode = (filt != FILT_EDGE);
  assign last_idx   = run_needed(filt) - 1'b1;

  assign edge_hit = act & ~act_q;
  assign lvl_hit  = tick & act & armed & (run >= last_idx);
  assign det      = en & (level_mode ? lvl_hit : edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      armed <= 1'b1;
    end else if (!en || !level_mode) begin
      run   <= '0;
      armed <= 1'b1;
    end else if (tick) begin
      if (act) begin
        if (run < last_idx) run <= run + 1'b1;
        if (lvl_hit)        armed <= 1'b0;
      end else begin
        run   <= '0;
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              ch0_pin_sel,
  input  logic [1:0]        ch_en,
  input  logic [1:0]        ch_pol,
  input  logic [FILT_W-1:0] filt_mode,
  input  logic [RATE_W-1:0] samp_rate,
  input  logic              ts_on_tamper,
  input  logic              irq_en,
  input  logic [1:0]        flag_clr,
  output logic [1:0]        flags,
  output logic              irq,
  output logic              ts_pulse,
  output logic              erase_pulse
);
  localparam int NCH = 2;

  logic           tick;
  logic [NCH-1:0] raw_pin;
  logic [NCH-1:0] sync_pin;
  logic [NCH-1:0] det_evt;
  logic           any_det;

  tamp_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .rate (samp_rate),
    .tick (tick)
  );

  assign raw_pin[0] = ch0_pin_sel ? pin_b : pin_a;
  assign raw_pin[1] = pin_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_pin[c]),
      .q    (sync_pin[c])
    );

    tamp_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .sin  (sync_pin[c]),
      .en   (ch_en[c]),
      .pol  (ch_pol[c]),
      .filt (filt_mode),
      .tick (tick),
      .det  (det_evt[c])
    );
  end

  assign any_det = |det_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags       <= '0;
      ts_pulse    <= 1'b0;
      erase_pulse <= 1'b0;
    end else begin
      flags       <= (flags & ~flag_clr) | det_evt;
      ts_pulse    <= any_det & ts_on_tamper;
      erase_pulse <= any_det;
    end
  end

  assign irq = irq_en & (|flags);
endmodule

// File: rtl/tamper_detect_chk.sv
module tamper_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ch_en,
  input logic [1:0] flag_clr,
  input logic [1:0] flags,
  input logic [1:0] det_evt,
  input logic       irq_en,
  input logic       irq,
  input logic       ts_pulse,
  input logic       erase_pulse
);
  p_sticky0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !flag_clr[0] |=> flags[0]);
  p_sticky1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !flag_clr[1] |=> flags[1]);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_evt) |=> ((flags & $past(det_evt)) == $past(det_evt)));
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_ts_with_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_pulse |-> erase_pulse);
  p_det_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_evt) |=> erase_pulse);
  p_erase_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> $past(|det_evt));
  p_en0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(ch_en[0]));
  p_en1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(ch_en[1]));
endmodule

bind tamper_detect tamper_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .flag_clr   (flag_clr),
  .flags      (flags),
  .det_evt    (det_evt),
  .irq_en     (irq_en),
  .irq        (irq),
  .ts_pulse   (ts_pulse),
  .erase_pulse(erase_pulse)
);

// File: tb/tb_tamper_detect.sv
module tb_tamper_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0, sel = 1'b0;
  logic [1:0] en = 2'b00, pol = 2'b00, clr = 2'b00;
  logic [1:0] filt = 2'd0;
  logic [2:0] rate = 3'd0;
  logic       ts_en = 1'b0, irq_en = 1'b0;
  logic [1:0] flags;
  logic       irq, ts_pulse, erase_pulse;

  int vectors = 0, fails = 0;
  int erase_seen = 0, ts_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .ch0_pin_sel(sel), .ch_en(en), .ch_pol(pol), .filt_mode(filt),
    .samp_rate(rate), .ts_on_tamper(ts_en), .irq_en(irq_en),
    .flag_clr(clr), .flags(flags), .irq(irq), .ts_pulse(ts_pulse),
    .erase_pulse(erase_pulse)
  );

  always @(negedge clk) begin
    if (erase_pulse) erase_seen++;
    if (ts_pulse)    ts_seen++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input int ch, input logic v);
    if (ch == 1 || sel) pin_b = v; else pin_a = v;
  endtask

  task automatic clear_all();
    clr = 2'b11; waitn(1); clr = 2'b00; waitn(1);
  endtask

  // disable, put both pins at the inactive level, then enable one channel
  task automatic setup(input int ch, input logic p, input logic [1:0] f, input logic [2:0] r);
    en = 2'b00; waitn(1);
    pol = {p, p}; filt = f; rate = r;
    pin_a = p; pin_b = p;
    waitn(4);
    clear_all();
    en = 2'b01 << ch; waitn(2);
  endtask

  task automatic edge_case(input int ch, input logic p, input logic s);
    int e0, t0;
    sel = s;
    setup(ch, p, 2'd0, 3'd0);
    ts_en = p; irq_en = 1'b1;
    e0 = erase_seen;
    // R1: activity on the pin this channel does not read
    if (ch == 0 && !s) begin pin_b = ~p; waitn(6); pin_b = p; end
    else begin pin_a = ~p; waitn(6); pin_a = p; end
    waitn(6);
    chk("R1 unselected pin ignored", {30'd0, flags}, 32'd0);
    chk("R1 no erase from unselected pin", erase_seen - e0, 0);
    e0 = erase_seen; t0 = ts_seen;
    drive(ch, ~p);
    waitn(2);
    chk("R2 flag not yet at edge 2", {30'd0, flags}, 32'd0);
    waitn(1);
    chk("R2 flag at edge 3", {30'd0, flags}, 32'd1 << ch);
    chk("R8 erase with flag", erase_pulse, 1);
    chk("R7 ts pulse follows enable", ts_pulse, p);
    chk("R6 irq with flag", irq, 1);
    waitn(1);
    chk("R8 erase one cycle", erase_pulse, 0);
    chk("R7 ts one cycle", ts_pulse, 0);
    drive(ch, p);           // opposite direction edge
    waitn(6);
    chk("R2 opposite edge no extra erase", erase_seen - e0, 1);
    chk("R7 ts count", ts_seen - t0, p ? 1 : 0);
    chk("R5 flag sticky", {30'd0, flags}, 32'd1 << ch);
    irq_en = 1'b0; waitn(1);
    chk("R6 irq masked", irq, 0);
    clear_all();
    chk("R5 flag cleared", {30'd0, flags}, 32'd0);
    en = 2'b00;
    drive(ch, ~p); waitn(5); drive(ch, p); waitn(5);
    chk("R9 disabled edge no flag", {30'd0, flags}, 32'd0);
    chk("R9 disabled edge no erase", erase_seen - e0, 1);
  endtask

  task automatic window(input int ch, input int need, input int per, input string tag);
    int e0;
    e0 = erase_seen;
    drive(ch, ~pol[ch]);
    waitn((need - 1) * per + 2);
    chk({tag, " flag low at earliest bound"}, {30'd0, flags}, 32'd0);
    waitn(per);
    chk({tag, " flag set by latest bound"}, {30'd0, flags}, 32'd1 << ch);
    waitn(2);
    chk("R8 one erase per level detection", erase_seen - e0, 1);
  endtask

  task automatic level_case(input int ch, input int f, input int r, input logic p);
    int need, per, e0;
    need = 1 << f;
    per  = 1 << (r + 1);
    setup(ch, p, 2'(f), 3'(r));
    ts_en = 1'b0;
    // R3: a run one sample short
    e0 = erase_seen;
    drive(ch, ~p); waitn((need - 1) * per); drive(ch, p);
    waitn(2 * per + 4);
    chk("R3 short run ignored", {30'd0, flags}, 32'd0);
    chk("R3 short run no erase", erase_seen - e0, 0);
    window(ch, need, per, "R4");
    clear_all();
    if (r <= 2) begin
      waitn(3 * need * per);
      chk("R10 no reflag while held active", {30'd0, flags}, 32'd0);
      drive(ch, p); waitn(2 * per + 4);
      window(ch, need, per, "R10");
      clear_all();
      // R9: disabled channel held active
      en = 2'b00; drive(ch, p); waitn(per + 4);
      e0 = erase_seen;
      drive(ch, ~p); waitn((need + 2) * per);
      chk("R9 disabled level no flag", {30'd0, flags}, 32'd0);
      chk("R9 disabled level no erase", erase_seen - e0, 0);
    end
    drive(ch, p);
  endtask

  initial begin
    waitn(3);
    chk("R11 flags at reset", {30'd0, flags}, 32'd0);
    chk("R11 irq at reset", irq, 0);
    chk("R11 pulses at reset", {30'd0, ts_pulse, erase_pulse}, 32'd0);
    rst_n = 1'b1;
    waitn(2);
    chk("R11 flags after reset", {30'd0, flags}, 32'd0);
    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          edge_case(ch, p[0], s[0]);
    for (int f = 1; f < 4; f++)
      for (int r = 0; r < 8; r++)
        level_case(r % 2, f, r, 1'((r >> 1) + f));
    sel = 1'b1;
    level_case(0, 1, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule